// File: doc/BRIEF.md
# Tagged Address Layout Remapper

This block sits on a load/store address path and converts an access to an object, written as a tagged pointer plus a byte offset, into the 48-bit address of the same field under a rearranged object layout. The upper 16 bits of the pointer carry a class identifier and the lower 48 bits carry the object's base. Two transformations can be enabled independently. The first is contraction, which halves both the base and the offset to undo a twofold field expansion. The second is reordering, which replaces the offset with the value held in a per-class permutation table.

Software, or a neighbouring block, fills the table through a write port for slot entries and a second write port for per-class attributes. The attributes are a bypass flag and the number of populated slots. Untagged pointers, tags beyond the table and bypassed classes skip both transformations. These cover object kinds such as primitive arrays and code objects, which keep their original layout. The result is registered once, so it appears one cycle after the request.

Top module: `obj_layout_remap`

## Requirements
- R1: `in_ptr[63:48]` is the class tag and `in_ptr[47:0]` is the base. Only these fields take part in the address computation.
- R2: A tag of zero passes through. The output is base plus offset, whatever the mode inputs are.
- R3: A tag equal to or above CLASSES (16) also passes through as base plus offset.
- R4: A class whose bypass attribute is 1 passes through as base plus offset, whatever the mode inputs are.
- R5: With contraction on and reordering off, a transformed access yields `(base >> 1) + (offset >> 1)`.
- R6: With reordering on, the slot is `offset[OFF_W-1:3]`. When the slot is below the class's populated count, the output is base + table[tag][slot] + `offset[2:0]`. The offset sum is taken modulo 2^OFF_W.
- R7: With reordering on, a slot at or beyond the populated count leaves the offset unchanged. An attribute write carries a count no larger than SLOTS.
- R8: With both modes on, contraction is applied first. The slot lookup and the byte-within-slot are then taken from the halved offset, and the halved base is used.
- R9: `out_valid` equals `in_valid` of the previous cycle. `out_addr` changes only after a cycle with `in_valid` high and otherwise holds its value.
- R10: A table or attribute write issued in the same cycle as an access does not affect that access. It affects accesses issued in any later cycle.
- R11: After synchronous active-low reset, `out_valid` and `out_addr` are 0. Every class has a populated count of 0 and a bypass of 0, so reordering leaves offsets unchanged.
- R12: With both modes off, a tagged access yields base plus offset. All address sums wrap modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_contract | input | 1 | Enable halving of base and offset |
| mode_reorder | input | 1 | Enable per-class offset permutation |
| in_valid | input | 1 | Access request strobe |
| in_ptr | input | 64 | Tagged pointer: tag in 63:48, base in 47:0 |
| in_off | input | 16 | Byte offset of the accessed field |
| map_we | input | 1 | Write one permutation slot |
| map_cls | input | 4 | Class index of the slot write |
| map_slot | input | 4 | Slot index of the slot write |
| map_data | input | 16 | New byte offset stored in the slot |
| attr_we | input | 1 | Write a class's attributes |
| attr_cls | input | 4 | Class index of the attribute write |
| attr_bypass | input | 1 | Bypass flag for the class |
| attr_count | input | 5 | Number of populated slots for the class |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_addr | output | 48 | Remapped address |

## Verification
The assertions assume that the mode inputs and the pointer stay steady in the cycle they are sampled. They also assume that no attribute write ever carries a count above SLOTS, a condition one property checks on the input. The bench drives all inputs only on falling edges and issues counts of 0 to 16. It changes table contents only for classes whose pending accesses it has already accounted for in its own model. Same-cycle write and access pairs are used deliberately, to confirm the old contents are still seen.

// File: rtl/remap_pkg.sv
// Shared constants and types for the tagged address layout remapper.
// Assumes a 64-bit pointer with the tag in its top 16 bits.
package remap_pkg;
    localparam int PTR_W      = 64;
    localparam int TAG_W      = 16;
    localparam int BASE_W     = PTR_W - TAG_W;
    localparam int SLOT_SHIFT = 3;   // slots are 8-byte units

    // Which arithmetic path produced an address.
    typedef enum logic {
        ROUTE_DIRECT = 1'b0,
        ROUTE_XFORM  = 1'b1
    } route_e;
endpackage

// File: rtl/remap_table.sv
// Per-class permutation storage and attributes.
// Holds CLASSES x SLOTS mapped offsets, plus a populated count and a bypass
// flag for each class. Reads are combinational. Writes land at the clock
// edge, so they are seen from the next cycle on.
// Assumes CLASSES and SLOTS are powers of two.
module remap_table #(
    parameter  int CLASSES = 16,
    parameter  int SLOTS   = 16,
    parameter  int OFF_W   = 16,
    localparam int CLS_W   = $clog2(CLASSES),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [CLS_W-1:0]  map_cls,
    input  logic [SLOT_W-1:0] map_slot,
    input  logic [OFF_W-1:0]  map_data,
    input  logic              attr_we,
    input  logic [CLS_W-1:0]  attr_cls,
    input  logic              attr_bypass,
    input  logic [CNT_W-1:0]  attr_count,
    input  logic [CLS_W-1:0]  lk_cls,
    input  logic [SLOT_W-1:0] lk_slot,
    output logic [OFF_W-1:0]  lk_map,
    output logic [CNT_W-1:0]  lk_count,
    output logic              lk_bypass
);
    localparam int DEPTH = CLASSES * SLOTS;

    logic [OFF_W-1:0] map_mem [DEPTH];
    logic [CNT_W-1:0] cnt_q   [CLASSES];
    logic             byp_q   [CLASSES];

    // Slot store: contents are gated by the count, so no reset is needed.
    always_ff @(posedge clk) begin
        if (map_we) begin
            map_mem[{map_cls, map_slot}] <= map_data;
        end
    end

    // One attribute register pair per class.
    for (genvar c = 0; c < CLASSES; c++) begin : g_cls
        // Reset clears the count and bypass; a matching write updates them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[c] <= '0;
                byp_q[c] <= 1'b0;
            end else if (attr_we && attr_cls == CLS_W'(c)) begin
                cnt_q[c] <= attr_count;
                byp_q[c] <= attr_bypass;
            end
        end
    end

    // Combinational lookup for the current access.
    always_comb begin
        lk_map    = map_mem[{lk_cls, lk_slot}];
        lk_count  = cnt_q[lk_cls];
        lk_bypass = byp_q[lk_cls];
    end

    // R7: an attribute write never declares more slots than exist.
    p_count_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        attr_we |-> (32'(attr_count) <= SLOTS));

    // R10: a slot write is readable at its location in the next cycle.
    p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (map_mem[$past({map_cls, map_slot})] == $past(map_data)));
endmodule

// File: rtl/remap_calc.sv
// Combinational address arithmetic.
// Decides between the direct path (base + offset) and the transformed path.
// On the transformed path it applies optional halving first, then an
// optional slot permutation from the table lookup it drives.
// Assumes the lookup it drives answers within the same cycle.
module remap_calc
    import remap_pkg::*;
#(
    parameter  int CLASSES = 16,
    parameter  int SLOTS   = 16,
    parameter  int OFF_W   = 16,
    localparam int CLS_W   = $clog2(CLASSES),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic [TAG_W-1:0]  tag,
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    input  logic              mode_contract,
    input  logic              mode_reorder,
    input  logic [OFF_W-1:0]  lk_map,
    input  logic [CNT_W-1:0]  lk_count,
    input  logic              lk_bypass,
    output logic [CLS_W-1:0]  lk_cls,
    output logic [SLOT_W-1:0] lk_slot,
    output logic [BASE_W-1:0] addr
);
    localparam int IDX_W = OFF_W - SLOT_SHIFT;

    logic              tag_known;
    logic [BASE_W-1:0] half_base;
    logic [OFF_W-1:0]  half_off;
    logic [IDX_W-1:0]  slot_idx;
    logic              slot_live;
    logic [OFF_W-1:0]  moved_off;
    logic [OFF_W-1:0]  eff_off;
    route_e            route;

    // Classify the tag and apply the contraction stage.
    always_comb begin
        tag_known = (tag != '0) && (32'(tag) < CLASSES);
        lk_cls    = tag[CLS_W-1:0];
        half_base = mode_contract ? (base >> 1) : base;
        half_off  = mode_contract ? (off >> 1)  : off;
    end

    // Reordering stage on the (possibly halved) offset.
    always_comb begin
        slot_idx  = half_off[OFF_W-1:SLOT_SHIFT];
        lk_slot   = half_off[SLOT_W+SLOT_SHIFT-1:SLOT_SHIFT];
        slot_live = 32'(slot_idx) < 32'(lk_count);
        moved_off = lk_map + OFF_W'(half_off[SLOT_SHIFT-1:0]);
        eff_off   = (mode_reorder && slot_live) ? moved_off : half_off;
    end

    // Pick the path and form the final address.
    always_comb begin
        route = (tag_known && !lk_bypass) ? ROUTE_XFORM : ROUTE_DIRECT;
        if (route == ROUTE_XFORM) begin
            addr = half_base + BASE_W'(eff_off);
        end else begin
            addr = base + BASE_W'(off);
        end
    end
endmodule

// File: rtl/obj_layout_remap.sv
// Tagged address layout remapper, top level.
// Splits the tagged pointer, computes the remapped address, and registers
// it together with a valid flag (one cycle of latency). Holds the table.
// Assumes the mode inputs are sampled together with each access.
module obj_layout_remap
    import remap_pkg::*;
#(
    parameter  int CLASSES = 16,
    parameter  int SLOTS   = 16,
    parameter  int OFF_W   = 16,
    localparam int CLS_W   = $clog2(CLASSES),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_contract,
    input  logic              mode_reorder,
    input  logic              in_valid,
    input  logic [PTR_W-1:0]  in_ptr,
    input  logic [OFF_W-1:0]  in_off,
    input  logic              map_we,
    input  logic [CLS_W-1:0]  map_cls,
    input  logic [SLOT_W-1:0] map_slot,
    input  logic [OFF_W-1:0]  map_data,
    input  logic              attr_we,
    input  logic [CLS_W-1:0]  attr_cls,
    input  logic              attr_bypass,
    input  logic [CNT_W-1:0]  attr_count,
    output logic              out_valid,
    output logic [BASE_W-1:0] out_addr
);
    logic [TAG_W-1:0]  ptr_tag;
    logic [BASE_W-1:0] ptr_base;
    logic [CLS_W-1:0]  lk_cls;
    logic [SLOT_W-1:0] lk_slot;
    logic [OFF_W-1:0]  lk_map;
    logic [CNT_W-1:0]  lk_count;
    logic              lk_bypass;
    logic [BASE_W-1:0] calc_addr;

    // Split the pointer into tag and base.
    always_comb begin
        ptr_tag  = in_ptr[PTR_W-1:BASE_W];
        ptr_base = in_ptr[BASE_W-1:0];
    end

    remap_table #(.CLASSES(CLASSES), .SLOTS(SLOTS), .OFF_W(OFF_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_we     (map_we),
        .map_cls    (map_cls),
        .map_slot   (map_slot),
        .map_data   (map_data),
        .attr_we    (attr_we),
        .attr_cls   (attr_cls),
        .attr_bypass(attr_bypass),
        .attr_count (attr_count),
        .lk_cls     (lk_cls),
        .lk_slot    (lk_slot),
        .lk_map     (lk_map),
        .lk_count   (lk_count),
        .lk_bypass  (lk_bypass)
    );

    remap_calc #(.CLASSES(CLASSES), .SLOTS(SLOTS), .OFF_W(OFF_W)) u_calc (
        .tag          (ptr_tag),
        .base         (ptr_base),
        .off          (in_off),
        .mode_contract(mode_contract),
        .mode_reorder (mode_reorder),
        .lk_map       (lk_map),
        .lk_count     (lk_count),
        .lk_bypass    (lk_bypass),
        .lk_cls       (lk_cls),
        .lk_slot      (lk_slot),
        .addr         (calc_addr)
    );

    // Output register: valid follows the request; the address loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= calc_addr;
            end
        end
    end

    // Reference sums used only by the properties below.
    logic [BASE_W-1:0] chk_pass_sum;
    logic [BASE_W-1:0] chk_half_sum;
    logic              chk_known;
    assign chk_pass_sum = ptr_base + BASE_W'(in_off);
    assign chk_half_sum = (ptr_base >> 1) + BASE_W'(in_off >> 1);
    assign chk_known    = (ptr_tag != '0) && (32'(ptr_tag) < CLASSES);

    p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr)));
    p_untagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ptr_tag == '0) |=> (out_addr == $past(chk_pass_sum)));
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_known && lk_bypass) |=> (out_addr == $past(chk_pass_sum)));
    p_contract_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_known && !lk_bypass && mode_contract && !mode_reorder)
        |=> (out_addr == $past(chk_half_sum)));
    p_plain_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_contract && !mode_reorder)
        |=> (out_addr == $past(chk_pass_sum)));
endmodule

// File: tb/obj_layout_remap_test.sv
module obj_layout_remap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_contract = 1'b0;
    logic        mode_reorder = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_ptr = '0;
    logic [15:0] in_off = '0;
    logic        map_we = 1'b0;
    logic [3:0]  map_cls = '0;
    logic [3:0]  map_slot = '0;
    logic [15:0] map_data = '0;
    logic        attr_we = 1'b0;
    logic [3:0]  attr_cls = '0;
    logic        attr_bypass = 1'b0;
    logic [4:0]  attr_count = '0;
    logic        out_valid;
    logic [47:0] out_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench-side model of the table contents.
    logic [15:0] bmap [16][16];
    int          bcnt [16];
    bit          bbyp [16];

    always #5 clk = ~clk;

    obj_layout_remap uut (
        .clk(clk), .rst_n(rst_n),
        .mode_contract(mode_contract), .mode_reorder(mode_reorder),
        .in_valid(in_valid), .in_ptr(in_ptr), .in_off(in_off),
        .map_we(map_we), .map_cls(map_cls), .map_slot(map_slot), .map_data(map_data),
        .attr_we(attr_we), .attr_cls(attr_cls), .attr_bypass(attr_bypass),
        .attr_count(attr_count),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    function automatic logic [47:0] model(logic [63:0] p, logic [15:0] o, bit c, bit r);
        logic [15:0] tg = p[63:48];
        logic [47:0] b  = p[47:0];
        logic [47:0] hb;
        logic [15:0] ho;
        if (tg == 16'd0 || tg >= 16'd16 || bbyp[tg[3:0]]) return b + {32'd0, o};
        hb = c ? (b >> 1) : b;
        ho = c ? (o >> 1) : o;
        if (r && int'(ho >> 3) < bcnt[tg[3:0]])
            ho = bmap[tg[3:0]][ho[6:3]] + {13'd0, ho[2:0]};
        return hb + {32'd0, ho};
    endfunction

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive on a falling edge, read the result one edge later.
    task automatic access(string req, logic [63:0] p, logic [15:0] o, bit c, bit r);
        logic [47:0] exp = model(p, o, c, r);
        @(negedge clk);
        in_valid = 1'b1; in_ptr = p; in_off = o; mode_contract = c; mode_reorder = r;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {47'd0, out_valid}, 48'd1);
        check(req, out_addr, exp);
    endtask

    task automatic put_map(logic [3:0] cls, logic [3:0] slot, logic [15:0] val);
        @(negedge clk);
        map_we = 1'b1; map_cls = cls; map_slot = slot; map_data = val;
        @(negedge clk);
        map_we = 1'b0;
        bmap[cls][slot] = val;
    endtask

    task automatic put_attr(logic [3:0] cls, bit byp, int cnt);
        @(negedge clk);
        attr_we = 1'b1; attr_cls = cls; attr_bypass = byp; attr_count = 5'(cnt);
        @(negedge clk);
        attr_we = 1'b0;
        bbyp[cls] = byp; bcnt[cls] = cnt;
    endtask

    task automatic t_reset();
        check("R11 out_valid after reset", {47'd0, out_valid}, 48'd0);
        check("R11 out_addr after reset", out_addr, 48'd0);
        access("R11 empty class reorders nothing", {16'd3, 48'h1000}, 16'h0C, 1'b0, 1'b1);
        check("R11 explicit pass value", out_addr, 48'h100C);
    endtask

    task automatic t_load_class3();
        put_map(4'd3, 4'd0, 16'h18);
        put_map(4'd3, 4'd1, 16'h00);
        put_map(4'd3, 4'd2, 16'h10);
        put_map(4'd3, 4'd3, 16'h08);
        put_attr(4'd3, 1'b0, 4);
    endtask

    task automatic t_untagged();
        access("R2 untagged both modes", {16'd0, 48'h2000}, 16'h0C, 1'b1, 1'b1);
        check("R2 explicit", out_addr, 48'h200C);
        access("R1 high tag bits only in tag", {16'h0000, 48'h8000_0000_0000}, 16'h4, 1'b1, 1'b1);
    endtask

    task automatic t_out_of_range();
        access("R3 tag 16 passes", {16'd16, 48'h2000}, 16'h0C, 1'b1, 1'b1);
        check("R3 explicit", out_addr, 48'h200C);
        access("R3 tag ffff passes", {16'hFFFF, 48'h4000}, 16'h28, 1'b1, 1'b1);
    endtask

    task automatic t_contract();
        access("R5 contraction", {16'd3, 48'h2000}, 16'h20, 1'b1, 1'b0);
        check("R5 explicit", out_addr, 48'h1010);
        access("R5 odd halves", {16'd7, 48'h3001}, 16'h0F, 1'b1, 1'b0);
    endtask

    task automatic t_reorder();
        access("R6 slot1 byte4", {16'd3, 48'h1000}, 16'h0C, 1'b0, 1'b1);
        check("R6 explicit", out_addr, 48'h1004);
        access("R6 slot0", {16'd3, 48'h1000}, 16'h00, 1'b0, 1'b1);
        check("R6 slot0 explicit", out_addr, 48'h1018);
        access("R6 slot3 byte7", {16'd3, 48'h1000}, 16'h1F, 1'b0, 1'b1);
    endtask

    task automatic t_beyond();
        access("R7 slot4 beyond count", {16'd3, 48'h1000}, 16'h20, 1'b0, 1'b1);
        check("R7 explicit", out_addr, 48'h1020);
        access("R7 far slot", {16'd3, 48'h1000}, 16'h7F0, 1'b0, 1'b1);
    endtask

    task automatic t_both();
        access("R8 contract then reorder", {16'd3, 48'h2000}, 16'h14, 1'b1, 1'b1);
        check("R8 explicit", out_addr, 48'h1002);
        access("R8 halved slot beyond", {16'd3, 48'h2000}, 16'h40, 1'b1, 1'b1);
    endtask

    task automatic t_plain_wrap();
        access("R12 no modes", {16'd3, 48'h1000}, 16'h0C, 1'b0, 1'b0);
        access("R12 wrap", {16'd5, 48'hFFFF_FFFF_FFF8}, 16'h10, 1'b0, 1'b0);
        check("R12 wrap explicit", out_addr, 48'h8);
    endtask

    task automatic t_bypass();
        put_map(4'd9, 4'd0, 16'h30);
        put_attr(4'd9, 1'b1, 1);
        access("R4 bypass both modes", {16'd9, 48'h2000}, 16'h04, 1'b1, 1'b1);
        check("R4 explicit", out_addr, 48'h2004);
        put_attr(4'd9, 1'b0, 1);
        access("R4 bypass cleared", {16'd9, 48'h2000}, 16'h04, 1'b0, 1'b1);
        check("R4 cleared explicit", out_addr, 48'h2034);
    endtask

    task automatic t_write_timing();
        logic [47:0] exp_old, exp_new;
        exp_old = model({16'd3, 48'h1000}, 16'h10, 1'b0, 1'b1);
        @(negedge clk);
        map_we = 1'b1; map_cls = 4'd3; map_slot = 4'd2; map_data = 16'h30;
        in_valid = 1'b1; in_ptr = {16'd3, 48'h1000}; in_off = 16'h10;
        mode_contract = 1'b0; mode_reorder = 1'b1;
        bmap[3][2] = 16'h30;
        exp_new = model({16'd3, 48'h1000}, 16'h10, 1'b0, 1'b1);
        @(negedge clk);
        map_we = 1'b0;
        check("R10 same-cycle write not seen", out_addr, exp_old);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 next-cycle write seen", out_addr, exp_new);
        check("R10 explicit", out_addr, 48'h1030);
    endtask

    task automatic t_hold();
        logic [47:0] last;
        access("R9 setup", {16'd3, 48'h5000}, 16'h08, 1'b0, 1'b1);
        last = out_addr;
        @(negedge clk);
        in_ptr = {16'd0, 48'hABCD}; in_off = 16'h1;
        @(negedge clk);
        check("R9 valid drops", {47'd0, out_valid}, 48'd0);
        check("R9 address held", out_addr, last);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            bcnt[i] = 0; bbyp[i] = 1'b0;
            for (int j = 0; j < 16; j++) bmap[i][j] = 16'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_class3();
        t_untagged();
        t_out_of_range();
        t_contract();
        t_reorder();
        t_beyond();
        t_both();
        t_plain_wrap();
        t_bypass();
        t_write_timing();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule